// File: doc/BRIEF.md
# Hot Plug Event Aggregator

The aggregator watches the hot plug signals of several PCIe slots. Each slot has six event kinds, and each kind has a status bit and an enable bit. The slot inputs set the status bits. Software clears them through a small register port.

The enabled, pending status bits of every slot are merged into one level. One global mode bit decides how that level is reported:

- **Legacy virtual-wire mode:** the block emits a single assert message when the merged level rises. It emits a single deassert message once software has cleared every enabled bit on every slot.
- **MSI mode:** each slot raises a one-cycle request when its first enabled event becomes pending.

Each slot also has a power-control bit that drives an active-low power enable pin.

The slot presence, power fault and latch inputs are asynchronous. They pass through a synchronizer before edge detection. The attention button, link-state-change and command-completed inputs are one-cycle pulses that are synchronous to `clk`.

Top module: `hp_event_agg`

## Requirements
- R1: A change in either direction on a slot's active-low presence input sets status bit 1 of that slot. The bit reads back as set after the third rising clock edge following the change, and not after the second.
- R2: A high-to-low transition on a slot's active-low power fault input sets status bit 3 three edges later. A low-to-high transition sets nothing.
- R3: A change in either direction on a slot's latch input sets status bit 2 three edges later.
- R4: A one-cycle pulse sets a status bit on the next edge: command completed sets bit 0, attention button sets bit 4, and link-state change sets bit 5.
- R5: Writes use `wr_sel_i` as follows:
  - 0 clears status: writing one to a bit clears it.
  - 1 writes the enable bits.
  - 2 writes the slot control register.
  - 3 writes the global mode, taken from data bit 3.
  - A hardware set in the same cycle as a status clear wins, so the bit stays set.
- R6: `pwr_en_n_o[p]` is low exactly when bit 0 of slot p's control register is set.
- R7: In legacy mode (mode bit 1), a single-cycle message with `msg_assert_o`=1 is sent when the OR of enabled pending bits over all slots rises. A pending bit whose enable is clear produces no message.
- R8: The deassert message (`msg_assert_o`=0) is sent only after every enabled pending bit on every slot is cleared. Clearing only some slots sends nothing. Assert and deassert messages strictly alternate, and the first message is an assert.
- R9: In MSI mode (mode bit 0), slot p raises `msi_req_o[p]` for one cycle when it goes from no enabled pending bit to at least one. Further events while one is pending raise nothing, and no messages are sent in this mode.
- R10: Switching from legacy to MSI mode while the virtual wire is asserted sends one deassert message on the second edge after the mode write.
- R11: After reset:
  - all status, enable and control bits are clear;
  - the mode is MSI;
  - `pwr_en_n_o` is all ones;
  - no message or MSI request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prsnt_n_i | input | NPORTS | Active-low card presence, asynchronous |
| pwrflt_n_i | input | NPORTS | Active-low power fault, asynchronous |
| latch_i | input | NPORTS | Retention latch status, asynchronous |
| button_i | input | NPORTS | Attention button pulse |
| link_chg_i | input | NPORTS | Link-state change pulse |
| cmd_done_i | input | NPORTS | Command completed pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status clear, 1 enable, 2 slot control, 3 mode |
| wr_port_i | input | PW | Slot addressed by the write |
| wr_data_i | input | 6 | Write data |
| rd_port_i | input | PW | Slot shown on the read outputs |
| rd_status_o | output | 6 | Status bits of the selected slot |
| rd_enable_o | output | 6 | Enable bits of the selected slot |
| pwr_en_n_o | output | NPORTS | Active-low power enable per slot |
| msi_req_o | output | NPORTS | One-cycle MSI request per slot |
| msg_valid_o | output | 1 | Virtual-wire message strobe |
| msg_assert_o | output | 1 | Message kind: 1 assert, 0 deassert |

## Verification
The assertions check four properties on every cycle:

- virtual-wire messages alternate, starting with an assert;
- an assert message never follows an MSI-mode cycle;
- MSI requests never last two cycles;
- the power enable pins follow each control write.

Some behaviour only the bench scenarios can show:

- the exact latency through the synchronizer;
- the choice of edge for power fault versus presence;
- priority of a hardware set over a software clear;
- withholding the deassert until the last slot is cleared;
- the forced deassert on a mode change.

// File: rtl/hp_agg_pkg.sv
package hp_agg_pkg;
   localparam int NEV = 6;
   // event positions within a slot's status and enable vectors
   localparam int EV_CMD    = 0;
   localparam int EV_PRES   = 1;
   localparam int EV_LATCH  = 2;
   localparam int EV_PFAULT = 3;
   localparam int EV_BTN    = 4;
   localparam int EV_LINK   = 5;
   localparam int MODE_BIT  = 3;
   localparam int PWR_BIT   = 0;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_PCTRL  = 2'd2,
      SEL_MISC   = 2'd3
   } wsel_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hp_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hp_port.sv
module hp_port
   import hp_agg_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prs_s,
   input  logic           pf_s,
   input  logic           lat_s,
   input  logic           btn,
   input  logic           lnk,
   input  logic           cmd,
   input  logic [NEV-1:0] clr,
   input  logic           en_wr,
   input  logic [NEV-1:0] en_data,
   input  logic           ctl_wr,
   input  logic           ctl_bit,
   input  logic           msi_mode,
   output logic [NEV-1:0] status,
   output logic [NEV-1:0] enable,
   output logic           pend_any,
   output logic           msi_req,
   output logic           pwr_en_n
);
   logic           prs_q, pf_q, lat_q;
   logic           any_q, ctl_q;
   logic [NEV-1:0] set;

   always_comb begin
      set            = '0;
      set[EV_CMD]    = cmd;
      set[EV_PRES]   = prs_s ^ prs_q;
      set[EV_LATCH]  = lat_s ^ lat_q;
      set[EV_PFAULT] = pf_q & ~pf_s;
      set[EV_BTN]    = btn;
      set[EV_LINK]   = lnk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prs_q  <= 1'b1;
         pf_q   <= 1'b1;
         lat_q  <= 1'b0;
         status <= '0;
         enable <= '0;
         ctl_q  <= 1'b0;
         any_q  <= 1'b0;
      end else begin
         prs_q  <= prs_s;
         pf_q   <= pf_s;
         lat_q  <= lat_s;
         // a hardware set overrides a same-cycle software clear
         status <= (status & ~clr) | set;
         if (en_wr)  enable <= en_data;
         if (ctl_wr) ctl_q  <= ctl_bit;
         any_q  <= pend_any;
      end
   end

   assign pend_any = |(status & enable);
   assign msi_req  = msi_mode & pend_any & ~any_q;
   assign pwr_en_n = ~ctl_q;
endmodule

// File: rtl/hp_gpe_fsm.sv
module hp_gpe_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic gpe_mode,
   output logic msg_valid,
   output logic msg_assert
);
   logic wire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wire_q     <= 1'b0;
         msg_valid  <= 1'b0;
         msg_assert <= 1'b0;
      end else begin
         msg_valid <= 1'b0;
         if (gpe_mode) begin
            if (level && !wire_q) begin
               wire_q     <= 1'b1;
               msg_valid  <= 1'b1;
               msg_assert <= 1'b1;
            end else if (!level && wire_q) begin
               wire_q     <= 1'b0;
               msg_valid  <= 1'b1;
               msg_assert <= 1'b0;
            end
         end else if (wire_q) begin
            // leaving legacy mode: release the virtual wire first
            wire_q     <= 1'b0;
            msg_valid  <= 1'b1;
            msg_assert <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hp_event_agg.sv
module hp_event_agg
   import hp_agg_pkg::*;
#(
   parameter  int NPORTS      = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int PW          = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] prsnt_n_i,
   input  logic [NPORTS-1:0] pwrflt_n_i,
   input  logic [NPORTS-1:0] latch_i,
   input  logic [NPORTS-1:0] button_i,
   input  logic [NPORTS-1:0] link_chg_i,
   input  logic [NPORTS-1:0] cmd_done_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [PW-1:0]     wr_port_i,
   input  logic [NEV-1:0]    wr_data_i,
   input  logic [PW-1:0]     rd_port_i,
   output logic [NEV-1:0]    rd_status_o,
   output logic [NEV-1:0]    rd_enable_o,
   output logic [NPORTS-1:0] pwr_en_n_o,
   output logic [NPORTS-1:0] msi_req_o,
   output logic              msg_valid_o,
   output logic              msg_assert_o
);
   if (NPORTS < 1) begin : g_bad_ports
      $error("hp_event_agg needs at least one slot");
   end

   logic [NPORTS-1:0] prs_s, pf_s, lat_s, pend_vec;
   logic [NEV-1:0]    status_arr [NPORTS];
   logic [NEV-1:0]    enable_arr [NPORTS];
   logic              gpe_mode_q;

   hp_sync #(.W(NPORTS), .STAGES(SYNC_STAGES), .RST_VAL({NPORTS{1'b1}})) u_sync_prs (
      .clk(clk), .rst_n(rst_n), .d(prsnt_n_i), .q(prs_s));
   hp_sync #(.W(NPORTS), .STAGES(SYNC_STAGES), .RST_VAL({NPORTS{1'b1}})) u_sync_pf (
      .clk(clk), .rst_n(rst_n), .d(pwrflt_n_i), .q(pf_s));
   hp_sync #(.W(NPORTS), .STAGES(SYNC_STAGES), .RST_VAL({NPORTS{1'b0}})) u_sync_lat (
      .clk(clk), .rst_n(rst_n), .d(latch_i), .q(lat_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             gpe_mode_q <= 1'b0;
      else if (wr_en_i && wr_sel_i == SEL_MISC) gpe_mode_q <= wr_data_i[MODE_BIT];
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic           hit;
      logic [NEV-1:0] clr;
      assign hit = wr_en_i && (int'(wr_port_i) == p);
      assign clr = (hit && wr_sel_i == SEL_STATUS) ? wr_data_i : '0;

      hp_port u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .prs_s    (prs_s[p]),
         .pf_s     (pf_s[p]),
         .lat_s    (lat_s[p]),
         .btn      (button_i[p]),
         .lnk      (link_chg_i[p]),
         .cmd      (cmd_done_i[p]),
         .clr      (clr),
         .en_wr    (hit && wr_sel_i == SEL_ENABLE),
         .en_data  (wr_data_i),
         .ctl_wr   (hit && wr_sel_i == SEL_PCTRL),
         .ctl_bit  (wr_data_i[PWR_BIT]),
         .msi_mode (~gpe_mode_q),
         .status   (status_arr[p]),
         .enable   (enable_arr[p]),
         .pend_any (pend_vec[p]),
         .msi_req  (msi_req_o[p]),
         .pwr_en_n (pwr_en_n_o[p])
      );
   end

   assign rd_status_o = (int'(rd_port_i) < NPORTS) ? status_arr[rd_port_i] : '0;
   assign rd_enable_o = (int'(rd_port_i) < NPORTS) ? enable_arr[rd_port_i] : '0;

   hp_gpe_fsm u_gpe (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (|pend_vec),
      .gpe_mode   (gpe_mode_q),
      .msg_valid  (msg_valid_o),
      .msg_assert (msg_assert_o)
   );
endmodule

// File: rtl/hp_event_agg_chk.sv
module hp_event_agg_chk #(
   parameter int NPORTS = 4,
   parameter int PW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic [1:0]        wr_sel_i,
   input logic [PW-1:0]     wr_port_i,
   input logic              wr_bit0,
   input logic [NPORTS-1:0] pwr_en_n_o,
   input logic [NPORTS-1:0] msi_req_o,
   input logic              msg_valid_o,
   input logic              msg_assert_o,
   input logic              gpe_mode_q
);
   logic last_assert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           last_assert <= 1'b0;
      else if (msg_valid_o) last_assert <= msg_assert_o;
   end

   // R8
   msg_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o |-> (msg_assert_o != last_assert));

   // R7
   assert_legacy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && msg_assert_o) |-> $past(gpe_mode_q));

   // R9
   msi_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(msi_req_o & $past(msi_req_o)) == 0);

   for (genvar p = 0; p < NPORTS; p++) begin : g_pwr
      // R6
      pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && wr_sel_i == 2'd2 && int'(wr_port_i) == p)
            |=> (pwr_en_n_o[p] == !$past(wr_bit0)));
   end
endmodule

bind hp_event_agg hp_event_agg_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en_i      (wr_en_i),
   .wr_sel_i     (wr_sel_i),
   .wr_port_i    (wr_port_i),
   .wr_bit0      (wr_data_i[0]),
   .pwr_en_n_o   (pwr_en_n_o),
   .msi_req_o    (msi_req_o),
   .msg_valid_o  (msg_valid_o),
   .msg_assert_o (msg_assert_o),
   .gpe_mode_q   (gpe_mode_q)
);

// File: tb/tb_hp_event_agg.sv
module tb_hp_event_agg;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] prsnt_n = '1, pwrflt_n = '1, latch = '0;
   logic [NP-1:0] button = '0, link_chg = '0, cmd_done = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [1:0]    wr_port = '0, rd_port = '0;
   logic [5:0]    wr_data = '0;
   logic [5:0]    rd_status, rd_enable;
   logic [NP-1:0] pwr_en_n, msi_req;
   logic          msg_valid, msg_assert;
   int            n_chk = 0, n_err = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hp_event_agg #(.NPORTS(NP)) dut (
      .clk(clk), .rst_n(rst_n),
      .prsnt_n_i(prsnt_n), .pwrflt_n_i(pwrflt_n), .latch_i(latch),
      .button_i(button), .link_chg_i(link_chg), .cmd_done_i(cmd_done),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_port_i(wr_port), .wr_data_i(wr_data),
      .rd_port_i(rd_port), .rd_status_o(rd_status), .rd_enable_o(rd_enable),
      .pwr_en_n_o(pwr_en_n), .msi_req_o(msi_req),
      .msg_valid_o(msg_valid), .msg_assert_o(msg_assert));

   // pulse table: [5:4] slot, [2:0] status bit driven by a pulse input
   localparam logic [5:0] PULSE_VEC [8] = '{
      6'h00, 6'h14, 6'h25, 6'h30, 6'h04, 6'h15, 6'h20, 6'h34 };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] port, input logic [5:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_port = port; wr_data = data;
      step(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input int kind, input int port);
      case (kind)
         0: cmd_done[port] = 1'b1;
         4: button[port]   = 1'b1;
         default: link_chg[port] = 1'b1;
      endcase
      step(1);
      button = '0; link_chg = '0; cmd_done = '0;
   endtask

   task automatic read_status(input logic [1:0] port, input string req, input logic [5:0] exp);
      rd_port = port;
      #1;
      chk(req, {26'd0, rd_status}, {26'd0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R11 reset state
      for (int p = 0; p < NP; p++) begin
         read_status(2'(p), "R11 status", 6'h00);
         chk("R11 enable", {26'd0, rd_enable}, 32'd0);
      end
      chk("R11 pwr_en_n", {28'd0, pwr_en_n}, 32'hF);
      chk("R11 msg", {31'd0, msg_valid}, 32'd0);
      chk("R11 msi", {28'd0, msi_req}, 32'd0);

      // R4 pulse table
      for (int i = 0; i < 8; i++) begin
         pulse(int'(PULSE_VEC[i][2:0]), int'(PULSE_VEC[i][5:4]));
         read_status(PULSE_VEC[i][5:4], "R4 pulse set", 6'(1) << PULSE_VEC[i][2:0]);
         wr(2'd0, PULSE_VEC[i][5:4], 6'h3F);
         read_status(PULSE_VEC[i][5:4], "R5 w1c clear", 6'h00);
      end

      // R1 presence, both directions, latency three edges
      prsnt_n[1] = 1'b0;
      step(2);
      read_status(2'd1, "R1 not yet", 6'h00);
      step(1);
      read_status(2'd1, "R1 fall", 6'h02);
      wr(2'd0, 2'd1, 6'h02);
      prsnt_n[1] = 1'b1;
      step(3);
      read_status(2'd1, "R1 rise", 6'h02);
      wr(2'd0, 2'd1, 6'h02);

      // R2 power fault assertion edge only
      pwrflt_n[0] = 1'b0;
      step(3);
      read_status(2'd0, "R2 fall", 6'h08);
      wr(2'd0, 2'd0, 6'h08);
      pwrflt_n[0] = 1'b1;
      step(4);
      read_status(2'd0, "R2 rise ignored", 6'h00);

      // R3 latch change
      latch[2] = 1'b1;
      step(3);
      read_status(2'd2, "R3 latch", 6'h04);
      wr(2'd0, 2'd2, 6'h04);
      read_status(2'd2, "R3 cleared", 6'h00);

      // R5 set wins over same-cycle clear
      button[1] = 1'b1;
      wr(2'd0, 2'd1, 6'h10);
      button = '0;
      read_status(2'd1, "R5 set priority", 6'h10);
      wr(2'd0, 2'd1, 6'h10);
      read_status(2'd1, "R5 clear", 6'h00);

      // R6 power enable
      wr(2'd2, 2'd2, 6'h01);
      chk("R6 on", {28'd0, pwr_en_n}, 32'hB);
      wr(2'd2, 2'd2, 6'h00);
      chk("R6 off", {28'd0, pwr_en_n}, 32'hF);

      // R7 legacy mode assert
      wr(2'd3, 2'd0, 6'h08);
      wr(2'd1, 2'd0, 6'h10);
      wr(2'd1, 2'd1, 6'h10);
      pulse(5, 2);       // not enabled
      step(1);
      chk("R7 disabled no msg", {31'd0, msg_valid}, 32'd0);
      wr(2'd0, 2'd2, 6'h20);
      pulse(4, 0);
      chk("R7 not early", {31'd0, msg_valid}, 32'd0);
      step(1);
      chk("R7 assert msg", {30'd0, msg_valid, msg_assert}, 32'd3);
      step(1);
      chk("R7 single cycle", {31'd0, msg_valid}, 32'd0);

      // R8 deassert only after all slots cleared
      pulse(4, 1);
      step(1);
      chk("R8 no second assert", {31'd0, msg_valid}, 32'd0);
      wr(2'd0, 2'd0, 6'h10);
      step(1);
      chk("R8 partial clear", {31'd0, msg_valid}, 32'd0);
      wr(2'd0, 2'd1, 6'h10);
      step(1);
      chk("R8 deassert msg", {30'd0, msg_valid, msg_assert}, 32'd2);
      step(1);
      chk("R8 quiet", {31'd0, msg_valid}, 32'd0);

      // R10 mode switch releases the wire
      pulse(4, 0);
      step(1);
      chk("R10 assert", {30'd0, msg_valid, msg_assert}, 32'd3);
      wr(2'd3, 2'd0, 6'h00);
      chk("R10 not yet", {31'd0, msg_valid}, 32'd0);
      step(1);
      chk("R10 deassert", {30'd0, msg_valid, msg_assert}, 32'd2);
      chk("R10 no msi", {28'd0, msi_req}, 32'd0);
      wr(2'd0, 2'd0, 6'h10);

      // R9 MSI mode
      wr(2'd1, 2'd3, 6'h30);
      pulse(4, 3);
      chk("R9 msi req", {28'd0, msi_req}, 32'h8);
      chk("R9 no msg", {31'd0, msg_valid}, 32'd0);
      step(1);
      chk("R9 one cycle", {28'd0, msi_req}, 32'd0);
      pulse(5, 3);
      chk("R9 already pending", {28'd0, msi_req}, 32'd0);
      step(1);
      chk("R9 no msg later", {31'd0, msg_valid}, 32'd0);
      wr(2'd0, 2'd3, 6'h30);
      step(1);
      pulse(4, 3);
      chk("R9 msi again", {28'd0, msi_req}, 32'h8);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule